// File: doc/BRIEF.md
# Segment-Based Address Translator

This block turns a 16-bit virtual address into a 16-bit physical address through a segment map of eight entries held in flip-flops. The three most significant address bits pick an entry. The remaining 13 bits form the offset within the segment. Each entry stores a base, a bound and a valid flag. The offset is checked against the bound of the selected entry and added to its base. A failed lookup returns an access error with a cause code instead of an address.

The map is loaded through a write port. The caller marks each write as coming from kernel mode or not. Only kernel-mode writes change the map. A write from user mode leaves the map untouched and raises a one-cycle denial flag. Translations use a valid/ready request channel and a valid/ready response channel. The response is registered, so it appears one clock after the request is accepted, and it stays held while the consumer stalls.

Top module: `seg_xlate`

## Requirements
- R1: After a synchronous active-low reset, every map entry is invalid, rsp_valid is 0 and cfg_wr_denied is 0. Any translation made before the first kernel write therefore faults with cause 01.
- R2: Bits [15:13] of req_vaddr select the entry. Bits [12:0] are the offset.
- R3: If the entry is valid and the offset is not greater than its bound, the response has rsp_err=0, rsp_cause=00 and rsp_paddr=(base+offset) mod 2^16.
- R4: If the entry is valid and the offset is greater than its bound, the response has rsp_err=1, rsp_cause=10 and rsp_paddr=0. An offset equal to the bound translates normally.
- R5: If the entry is invalid, the response has rsp_err=1, rsp_cause=01 and rsp_paddr=0, whatever the bound comparison gives. Cause 11 never occurs.
- R6: A write with cfg_wr_en=1 and cfg_wr_kernel=1 loads base, bound and valid into entry cfg_wr_idx. The new values apply to requests accepted in later cycles. A request accepted in the same cycle as the write still sees the old entry.
- R7: A write with cfg_wr_en=1 and cfg_wr_kernel=0 changes no entry. cfg_wr_denied is 1 for exactly the cycle after such a write, and 0 otherwise.
- R8: A request is accepted on a clock edge where req_valid and req_ready are both 1. Its response shows rsp_valid=1 from the next cycle. The response holds stable until a clock edge where rsp_ready=1.
- R9: req_ready equals (not rsp_valid) or rsp_ready. This allows one accepted request per cycle when the consumer never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Map write strobe |
| cfg_wr_kernel | input | 1 | 1 when the write comes from kernel mode |
| cfg_wr_idx | input | 3 | Entry to write |
| cfg_wr_base | input | 16 | New base |
| cfg_wr_bound | input | 16 | New bound (largest legal offset) |
| cfg_wr_valid | input | 1 | New valid flag |
| cfg_wr_denied | output | 1 | One-cycle flag after a refused user-mode write |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 16 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 16 | Physical address, 0 on error |
| rsp_err | output | 1 | Access error |
| rsp_cause | output | 2 | 00 ok, 01 invalid entry, 10 bound exceeded |

## Verification
The bench probes offsets equal to the bound and one past it. A design with an off-by-one compare would either reject the last legal byte or let the first illegal one through. It uses an entry that is both invalid and out of bound, and a wrong priority there would report cause 10. It uses a base near the top of the space to exercise the modulo wrap. It also sends a user-mode write onto a live entry, and a design that did not gate the write would move the later translation. A request is issued in the same cycle as a kernel write, and a design that forwarded the write would return the new address. Random back-pressure on the response channel shows up any response that changes or gets lost during a stall.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the segment translator: the fault cause encoding.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_NOSEG = 2'b01,
        CAUSE_BOUND = 2'b10
    } seg_cause_e;
endpackage

// File: rtl/seg_map_regs.sv
// Segment map storage. It holds one base/bound/valid set per entry in flops.
// Assumes the caller presents the privilege of each write on wr_kernel.
// Writes from user mode are dropped and reported one cycle later on denied_o.
module seg_map_regs #(
    parameter int N_SEG  = 8,
    parameter int IDX_W  = 3,
    parameter int BASE_W = 16,
    parameter int BND_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           wr_kernel,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [BASE_W-1:0]              wr_base,
    input  logic [BND_W-1:0]               wr_bound,
    input  logic                           wr_valid,
    output logic [N_SEG-1:0][BASE_W-1:0]   base_o,
    output logic [N_SEG-1:0][BND_W-1:0]    bound_o,
    output logic [N_SEG-1:0]               valid_o,
    output logic                           denied_o
);
    logic wr_ok;

    // Qualify a write with kernel privilege
    always_comb wr_ok = wr_en && wr_kernel;

    for (genvar g = 0; g < N_SEG; g++) begin : g_ent
        // Hold one entry; clear to invalid on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g]  <= '0;
                bound_o[g] <= '0;
                valid_o[g] <= 1'b0;
            end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
                base_o[g]  <= wr_base;
                bound_o[g] <= wr_bound;
                valid_o[g] <= wr_valid;
            end
        end
    end

    // Flag a refused user-mode write for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) denied_o <= 1'b0;
        else        denied_o <= wr_en && !wr_kernel;
    end
endmodule

// File: rtl/seg_xlate_calc.sv
// Combinational lookup. It splits the address, picks the entry, checks the
// bound and forms base+offset. An invalid entry takes priority over a bound
// fault. The address is forced to zero on any fault.
module seg_xlate_calc
    import seg_xlate_pkg::*;
#(
    parameter int N_SEG  = 8,
    parameter int SEG_W  = 3,
    parameter int VA_W   = 16,
    parameter int PA_W   = 16,
    parameter int BND_W  = 16
) (
    input  logic [VA_W-1:0]              vaddr,
    input  logic [N_SEG-1:0][PA_W-1:0]   base_i,
    input  logic [N_SEG-1:0][BND_W-1:0]  bound_i,
    input  logic [N_SEG-1:0]             valid_i,
    output logic [PA_W-1:0]              paddr,
    output seg_cause_e                   cause
);
    localparam int OFF_W = VA_W - SEG_W;
    localparam int CMP_W = (OFF_W > BND_W) ? OFF_W : BND_W;

    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [PA_W-1:0]  sel_base;
    logic [BND_W-1:0] sel_bound;
    logic             sel_valid;
    logic             over;

    // Split the virtual address into segment number and offset
    always_comb begin
        seg = vaddr[VA_W-1 -: SEG_W];
        off = vaddr[OFF_W-1:0];
    end

    // Select the addressed entry
    always_comb begin
        sel_base  = base_i[seg];
        sel_bound = bound_i[seg];
        sel_valid = valid_i[seg];
    end

    // Compare the offset with the bound and pick the fault cause
    always_comb begin
        over = CMP_W'(off) > CMP_W'(sel_bound);
        if (!sel_valid)  cause = CAUSE_NOSEG;
        else if (over)   cause = CAUSE_BOUND;
        else             cause = CAUSE_NONE;
    end

    // Form the physical address, zero when faulting
    always_comb begin
        if (cause == CAUSE_NONE) paddr = sel_base + PA_W'(off);
        else                     paddr = '0;
    end
endmodule

// File: rtl/seg_xlate_rsp.sv
// Response register with a valid/ready handshake on each side.
// It captures one result per accepted request and holds it until taken.
// The ready output depends combinationally on rsp_ready.
module seg_xlate_rsp
    import seg_xlate_pkg::*;
#(
    parameter int PA_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PA_W-1:0]  paddr_i,
    input  seg_cause_e       cause_i,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_err,
    output logic [1:0]       rsp_cause
);
    logic accept;

    // Accept when the output slot is empty or being drained
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        accept    = req_valid && req_ready;
    end

    // Track occupancy of the response slot
    always_ff @(posedge clk) begin
        if (!rst_n)        rsp_valid <= 1'b0;
        else if (accept)   rsp_valid <= 1'b1;
        else if (rsp_ready) rsp_valid <= 1'b0;
    end

    // Capture the translation result on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr <= '0;
            rsp_err   <= 1'b0;
            rsp_cause <= 2'b00;
        end else if (accept) begin
            rsp_paddr <= paddr_i;
            rsp_err   <= (cause_i != CAUSE_NONE);
            rsp_cause <= cause_i;
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Segment-based address translator top. It joins the map storage, the lookup
// and the response register. A map write and a request in the same cycle
// resolve with the request seeing the old map.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int SEG_W = 3,
    parameter int PA_W  = 16,
    parameter int BND_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_wr_kernel,
    input  logic [SEG_W-1:0] cfg_wr_idx,
    input  logic [PA_W-1:0]  cfg_wr_base,
    input  logic [BND_W-1:0] cfg_wr_bound,
    input  logic             cfg_wr_valid,
    output logic             cfg_wr_denied,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_err,
    output logic [1:0]       rsp_cause
);
    localparam int N_SEG = 1 << SEG_W;

    logic [N_SEG-1:0][PA_W-1:0]  map_base;
    logic [N_SEG-1:0][BND_W-1:0] map_bound;
    logic [N_SEG-1:0]            map_valid;
    logic [PA_W-1:0]             calc_paddr;
    seg_cause_e                  calc_cause;

    seg_map_regs #(
        .N_SEG(N_SEG), .IDX_W(SEG_W), .BASE_W(PA_W), .BND_W(BND_W)
    ) i_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_kernel(cfg_wr_kernel), .wr_idx(cfg_wr_idx),
        .wr_base(cfg_wr_base), .wr_bound(cfg_wr_bound), .wr_valid(cfg_wr_valid),
        .base_o(map_base), .bound_o(map_bound), .valid_o(map_valid),
        .denied_o(cfg_wr_denied)
    );

    seg_xlate_calc #(
        .N_SEG(N_SEG), .SEG_W(SEG_W), .VA_W(VA_W), .PA_W(PA_W), .BND_W(BND_W)
    ) i_calc (
        .vaddr(req_vaddr), .base_i(map_base), .bound_i(map_bound),
        .valid_i(map_valid), .paddr(calc_paddr), .cause(calc_cause)
    );

    seg_xlate_rsp #(.PA_W(PA_W)) i_rsp (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .paddr_i(calc_paddr), .cause_i(calc_cause),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_err(rsp_err), .rsp_cause(rsp_cause)
    );
endmodule

// File: rtl/seg_xlate_chk.sv
// Protocol and encoding checks for seg_xlate, attached by bind.
module seg_xlate_chk #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16,
    parameter int BND_W = 16,
    parameter int VA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic             cfg_wr_kernel,
    input logic             cfg_wr_denied,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_err,
    input logic [1:0]       rsp_cause
);
    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
                                    && $stable(rsp_err) && $stable(rsp_cause));

    assert_accept_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    assert_ready_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    assert_err_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_paddr == '0 && rsp_cause != 2'b00);

    assert_ok_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_err |-> rsp_cause == 2'b00);

    assert_no_cause3_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_cause != 2'b11);

    assert_denied_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en && !cfg_wr_kernel |=> cfg_wr_denied);

    assert_denied_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_denied |-> $past(cfg_wr_en && !cfg_wr_kernel));
endmodule

bind seg_xlate seg_xlate_chk #(
    .SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W), .VA_W(VA_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_kernel(cfg_wr_kernel), .cfg_wr_denied(cfg_wr_denied),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
    .rsp_cause(rsp_cause)
);

// File: tb/test_seg_xlate.sv
// Bench for seg_xlate: behavioural reference model compared every cycle.
module test_seg_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_wr_kernel = 1'b0, cfg_wr_valid = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [15:0] cfg_wr_base = '0, cfg_wr_bound = '0;
    logic        cfg_wr_denied;
    logic        req_valid = 1'b0, req_ready;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid, rsp_ready = 1'b1, rsp_err;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_cause;

    int n_tests = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    seg_xlate i_seg_xlate (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int m_base[8], m_bound[8];
    bit m_valid[8];
    bit m_rv, m_err, m_den;
    int m_paddr, m_cause;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_valid[i] <= 0; m_base[i] <= 0; m_bound[i] <= 0;
            end
            m_rv <= 0; m_den <= 0; m_paddr <= 0; m_err <= 0; m_cause <= 0;
        end else begin
            automatic int seg = req_vaddr[15:13];
            automatic int off = req_vaddr[12:0];
            m_den <= cfg_wr_en && !cfg_wr_kernel;
            if (cfg_wr_en && cfg_wr_kernel) begin
                m_base[cfg_wr_idx]  <= cfg_wr_base;
                m_bound[cfg_wr_idx] <= cfg_wr_bound;
                m_valid[cfg_wr_idx] <= cfg_wr_valid;
            end
            if (req_valid && (!m_rv || rsp_ready)) begin
                m_rv <= 1;
                if (!m_valid[seg]) begin
                    m_err <= 1; m_cause <= 1; m_paddr <= 0;
                end else if (off > m_bound[seg]) begin
                    m_err <= 1; m_cause <= 2; m_paddr <= 0;
                end else begin
                    m_err <= 0; m_cause <= 0;
                    m_paddr <= (m_base[seg] + off) % 65536;
                end
            end else if (rsp_ready) begin
                m_rv <= 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs with the model once per cycle, after inputs settle
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(rsp_valid == m_rv, "R8 rsp_valid", rsp_valid, m_rv);
            check(req_ready == (!m_rv || rsp_ready), "R9 req_ready", req_ready, !m_rv || rsp_ready);
            check(cfg_wr_denied == m_den, "R7 cfg_wr_denied", cfg_wr_denied, m_den);
            if (m_rv && rsp_valid) begin
                check(rsp_err == m_err, "R4/R5 rsp_err", rsp_err, m_err);
                check(rsp_cause == m_cause[1:0], "R4/R5 rsp_cause", rsp_cause, m_cause);
                check(rsp_paddr == m_paddr[15:0], "R3 rsp_paddr", rsp_paddr, m_paddr);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic cfg(input int idx, input int base, input int bnd, input bit v, input bit kern);
        cfg_wr_en = 1; cfg_wr_kernel = kern; cfg_wr_idx = 3'(idx);
        cfg_wr_base = 16'(base); cfg_wr_bound = 16'(bnd); cfg_wr_valid = v;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic send(input int seg, input int off);
        req_valid = 1; req_vaddr = {3'(seg), 13'(off)};
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports, checked while reset is still held
        check(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
        check(cfg_wr_denied == 0, "R1 denied after reset", cfg_wr_denied, 0);
        rst_n = 1;
        @(negedge clk);
        // R1: every entry starts invalid
        for (int s = 0; s < 8; s++) send(s, 0);
        // R7: user-mode write refused, entry stays invalid
        cfg(2, 16'h1000, 16'h1FFF, 1, 0);
        send(2, 5);
        // R6: kernel writes load entries
        cfg(0, 16'h4000, 16'h0FFF, 1, 1);
        cfg(1, 16'hF000, 16'h1FFF, 1, 1);
        cfg(2, 16'h2000, 16'h0010, 0, 1);
        cfg(5, 16'h1234, 16'h0100, 1, 1);
        cfg(7, 16'h8000, 16'h1FFF, 1, 1);
        // R2/R3/R4: bound edges, wrap, priority (R5)
        send(0, 0); send(0, 16'h0FFF); send(0, 16'h1000);
        send(1, 16'h1800);
        send(2, 16'h1FFF); send(2, 3);
        send(5, 16'h0100); send(5, 16'h0101);
        send(7, 16'h1FFF);
        // R7: user write over a live entry is ignored
        cfg(0, 16'h0000, 16'h0000, 0, 0);
        send(0, 16'h0123);
        // R6: write and request in the same cycle see the old entry
        cfg_wr_en = 1; cfg_wr_kernel = 1; cfg_wr_idx = 3'd5;
        cfg_wr_base = 16'h6000; cfg_wr_bound = 16'h1FFF; cfg_wr_valid = 1;
        req_valid = 1; req_vaddr = {3'd5, 13'h0050};
        @(negedge clk);
        cfg_wr_en = 0; req_valid = 0;
        send(5, 16'h0050);
        // R8/R9: stall the response with the request held
        rsp_ready = 0;
        req_valid = 1; req_vaddr = {3'd7, 13'h0004};
        repeat (4) @(negedge clk);
        rsp_ready = 1;
        repeat (2) @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        // R8/R9: back-to-back stream under random back-pressure
        for (int k = 0; k < 400; k++) begin
            rsp_ready = ($urandom % 4) != 0;
            req_valid = ($urandom % 3) != 0;
            req_vaddr = 16'($urandom);
            if (k % 37 == 0) begin
                cfg_wr_en = 1; cfg_wr_kernel = ($urandom % 2) != 0;
                cfg_wr_idx = 3'($urandom); cfg_wr_base = 16'($urandom);
                cfg_wr_bound = 16'($urandom % 16'h2000); cfg_wr_valid = ($urandom % 4) != 0;
            end else begin
                cfg_wr_en = 0;
            end
            @(negedge clk);
        end
        req_valid = 0; cfg_wr_en = 0; rsp_ready = 1;
        repeat (3) @(negedge clk);
        #2;
        finish_run();
    end
endmodule